// File: doc/BRIEF.md
# Reuse-Based Insertion Position Selector

This block decides where a newly filled line enters the recency stack of a 16-way last-level cache, or whether it should skip the cache entirely. Each fill request carries four inputs:

- a flag from the access map saying whether the line was touched before;
- the zone's reuse count and access count;
- a reuse class for the instruction that caused the miss.

From these the adaptive policy starts at the least-recent end of the stack. It moves the line closer to the most-recent end by repeated halving, and it can force or release the position depending on the instruction class. The line is bypassed when the instruction is marked as not worth caching, or when the zone is accessed far more often than it is reused.

A set-dueling controller picks the policy for each set. A small group of sets always inserts at the most-recent position (plain LRU behaviour), and a second group always uses the adaptive policy. Misses in those groups steer a saturating policy-select counter, and the counter's top bit picks the policy for all other sets. When the counter sits close to either end, most dedicated sets are handed back to the followers. Full dedication returns once the counter drifts back to its middle range.

The decision is registered and appears one cycle after the request. The stack update itself belongs to the cache.

Top module: `reuse_insert_sel`

## Requirements
- R1: A decision is valid (`dec_valid`=1) exactly one clock after a cycle with `req_valid`=1, and `dec_valid` is 0 after a cycle without a request.
- R2: Under the adaptive policy the position starts at 15. It is halved (integer division) when `req_map_reuse` is 1, and halved again when `req_zone_reuse` is strictly greater than `req_zone_access`.
- R3: Class codes on `req_class` are: 0 skip, 1 useless, 2 normal, 3 useful, 4 reuse, and 5 to 7 act as normal. After R2, useful halves the position, reuse forces 0, useless forces 15, and normal leaves it unchanged.
- R4: Under the adaptive policy `dec_bypass` is 1 when the class is skip (0), or when `req_zone_access` is greater than 16 times `req_zone_reuse`.
- R5: When a set uses the LRU policy, `dec_pos` is 0 and `dec_bypass` is 0.
- R6: Let U be `set[9:5]` and L be `set[4:0]`. A set with U==L is LRU-dedicated and a set with U==~L is adaptive-dedicated. All other sets are followers. `dec_adaptive` reports which policy produced the decision.
- R7: The 10-bit select counter resets to 512. A miss (`miss_valid`) in an LRU-dedicated set increments it, saturating at 1023. A miss in an adaptive-dedicated set decrements it, saturating at 0. Follower sets use the adaptive policy when the counter MSB is 1, which includes the state just after reset.
- R8: When the counter is at or below 63, or at or above 960, the block enters reduced mode one clock later. In reduced mode only dedicated sets with U<8 stay dedicated, and the others act as followers for both decisions and counter updates. Reduced mode ends one clock after the counter is back in 256 to 767.
- R9: After reset `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request present |
| req_set | input | 10 | Set index of the fill |
| req_map_reuse | input | 1 | Access map saw this line before |
| req_zone_reuse | input | 8 | Zone reuse count |
| req_zone_access | input | 8 | Zone access count |
| req_class | input | 3 | Instruction reuse class |
| miss_valid | input | 1 | Cache miss event for dueling |
| miss_set | input | 10 | Set index of the miss |
| dec_valid | output | 1 | Decision valid |
| dec_bypass | output | 1 | Do not allocate the line |
| dec_pos | output | 4 | Insertion depth, 0 = most recent |
| dec_adaptive | output | 1 | Decision used the adaptive policy |

## Verification
The position logic is driven through a table of input combinations. The table separates each halving step from the others: map reuse alone, zone ratio alone, both together, each class on top of both, a reserved class code, and the bypass ratio exactly at and just past sixteen. The same skip-class inputs are then sent to an LRU-dedicated set, an adaptive-dedicated set and a follower set, which shows that the set classification is in force. Long miss bursts push the select counter into both saturation limits. Follower decisions reveal the counter's top bit, which shows that the counter stopped at each limit rather than wrapping. A set that loses its dedication shows reduced mode: its policy flips to the follower's, misses on it leave the counter alone, and the count at which it regains dedication shows the hysteresis.

// File: rtl/ris_pkg.sv
package ris_pkg;
   typedef enum logic [2:0] {
      CLS_SKIP    = 3'd0,
      CLS_USELESS = 3'd1,
      CLS_NORMAL  = 3'd2,
      CLS_USEFUL  = 3'd3,
      CLS_REUSE   = 3'd4
   } ris_class_e;

   typedef enum logic [1:0] {
      KIND_FOLLOW = 2'd0,
      KIND_LRU    = 2'd1,
      KIND_ADAPT  = 2'd2
   } set_kind_e;
endpackage

// File: rtl/ris_depth_calc.sv
module ris_depth_calc
   import ris_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int POS_W        = 4,
   parameter int BYPASS_SHIFT = 4
) (
   input  logic             map_reuse,
   input  logic [CNT_W-1:0] zone_reuse,
   input  logic [CNT_W-1:0] zone_access,
   input  logic [2:0]       cls,
   output logic [POS_W-1:0] pos,
   output logic             bypass
);
   localparam int EXT_W = CNT_W + BYPASS_SHIFT;
   localparam logic [POS_W-1:0] START = {POS_W{1'b1}};

   logic [EXT_W-1:0] access_ext;
   logic [EXT_W-1:0] reuse_scaled;
   logic [POS_W-1:0] p;

   assign access_ext   = {{BYPASS_SHIFT{1'b0}}, zone_access};
   assign reuse_scaled = {zone_reuse, {BYPASS_SHIFT{1'b0}}};

   always_comb begin
      p = START;
      if (map_reuse)
         p = p >> 1;
      if (zone_reuse > zone_access)
         p = p >> 1;
      case (cls)
         CLS_REUSE:   p = '0;
         CLS_USEFUL:  p = p >> 1;
         CLS_USELESS: p = START;
         default:     p = p;
      endcase
      pos    = p;
      bypass = (cls == CLS_SKIP) || (access_ext > reuse_scaled);
   end
endmodule

// File: rtl/ris_set_class.sv
module ris_set_class
   import ris_pkg::*;
#(
   parameter int SET_W  = 10,
   parameter int KEEP_W = 3
) (
   input  logic [SET_W-1:0] set_idx,
   input  logic             reduced,
   output set_kind_e        kind
);
   localparam int HALF_W = SET_W / 2;

   logic [HALF_W-1:0] upper;
   logic [HALF_W-1:0] lower;
   logic              kept;
   logic              allowed;

   assign upper   = set_idx[SET_W-1:HALF_W];
   assign lower   = set_idx[HALF_W-1:0];
   assign kept    = (upper >> KEEP_W) == '0;
   assign allowed = !reduced || kept;

   always_comb begin
      if (allowed && (upper == lower))
         kind = KIND_LRU;
      else if (allowed && (upper == ~lower))
         kind = KIND_ADAPT;
      else
         kind = KIND_FOLLOW;
   end
endmodule

// File: rtl/ris_duel_ctrl.sv
module ris_duel_ctrl
   import ris_pkg::*;
#(
   parameter int PSEL_W    = 10,
   parameter int MARGIN    = 64,
   parameter bit REDUCE_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      miss_valid,
   input  set_kind_e miss_kind,
   output logic      follow_adapt,
   output logic      reduced_q
);
   localparam logic [PSEL_W-1:0] PMAX   = {PSEL_W{1'b1}};
   localparam logic [PSEL_W-1:0] PMID   = PSEL_W'(1) << (PSEL_W - 1);
   localparam logic [PSEL_W-1:0] LO_END = PSEL_W'(MARGIN);
   localparam logic [PSEL_W-1:0] HI_END = PMAX - PSEL_W'(MARGIN);
   localparam logic [PSEL_W-1:0] MID_LO = PMID >> 1;
   localparam logic [PSEL_W-1:0] MID_HI = PMID + (PMID >> 1) - PSEL_W'(1);

   logic [PSEL_W-1:0] psel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         psel_q <= PMID;
      else if (miss_valid && (miss_kind == KIND_LRU) && (psel_q != PMAX))
         psel_q <= psel_q + PSEL_W'(1);
      else if (miss_valid && (miss_kind == KIND_ADAPT) && (psel_q != '0))
         psel_q <= psel_q - PSEL_W'(1);
   end

   assign follow_adapt = psel_q[PSEL_W-1];

   generate
      if (REDUCE_EN) begin : g_reduce
         logic extreme;
         logic middle;
         assign extreme = (psel_q < LO_END) || (psel_q > HI_END);
         assign middle  = (psel_q >= MID_LO) && (psel_q <= MID_HI);
         always_ff @(posedge clk) begin
            if (!rst_n)
               reduced_q <= 1'b0;
            else if (!reduced_q && extreme)
               reduced_q <= 1'b1;
            else if (reduced_q && middle)
               reduced_q <= 1'b0;
         end
      end else begin : g_fixed
         assign reduced_q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/reuse_insert_sel.sv
module reuse_insert_sel
   import ris_pkg::*;
#(
   parameter int SET_W        = 10,
   parameter int KEEP_W       = 3,
   parameter int CNT_W        = 8,
   parameter int POS_W        = 4,
   parameter int BYPASS_SHIFT = 4,
   parameter int PSEL_W       = 10,
   parameter int MARGIN       = 64,
   parameter bit REDUCE_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [SET_W-1:0] req_set,
   input  logic             req_map_reuse,
   input  logic [CNT_W-1:0] req_zone_reuse,
   input  logic [CNT_W-1:0] req_zone_access,
   input  logic [2:0]       req_class,
   input  logic             miss_valid,
   input  logic [SET_W-1:0] miss_set,
   output logic             dec_valid,
   output logic             dec_bypass,
   output logic [POS_W-1:0] dec_pos,
   output logic             dec_adaptive
);
   if (SET_W % 2 != 0) begin : g_bad_set
      $error("SET_W must be even");
   end
   if (KEEP_W > SET_W / 2) begin : g_bad_keep
      $error("KEEP_W exceeds half of SET_W");
   end
   if (4 * MARGIN >= (1 << PSEL_W)) begin : g_bad_margin
      $error("MARGIN overlaps the middle range");
   end

   set_kind_e        req_kind;
   set_kind_e        miss_kind;
   logic             reduced;
   logic             follow_adapt;
   logic             use_adapt;
   logic [POS_W-1:0] calc_pos;
   logic             calc_bypass;

   ris_set_class #(.SET_W(SET_W), .KEEP_W(KEEP_W)) u_req_class (
      .set_idx (req_set),
      .reduced (reduced),
      .kind    (req_kind)
   );

   ris_set_class #(.SET_W(SET_W), .KEEP_W(KEEP_W)) u_miss_class (
      .set_idx (miss_set),
      .reduced (reduced),
      .kind    (miss_kind)
   );

   ris_duel_ctrl #(.PSEL_W(PSEL_W), .MARGIN(MARGIN), .REDUCE_EN(REDUCE_EN)) u_duel (
      .clk          (clk),
      .rst_n        (rst_n),
      .miss_valid   (miss_valid),
      .miss_kind    (miss_kind),
      .follow_adapt (follow_adapt),
      .reduced_q    (reduced)
   );

   ris_depth_calc #(.CNT_W(CNT_W), .POS_W(POS_W), .BYPASS_SHIFT(BYPASS_SHIFT)) u_depth (
      .map_reuse   (req_map_reuse),
      .zone_reuse  (req_zone_reuse),
      .zone_access (req_zone_access),
      .cls         (req_class),
      .pos         (calc_pos),
      .bypass      (calc_bypass)
   );

   assign use_adapt = (req_kind == KIND_ADAPT) ||
                      ((req_kind == KIND_FOLLOW) && follow_adapt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid    <= 1'b0;
         dec_bypass   <= 1'b0;
         dec_pos      <= '0;
         dec_adaptive <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         if (req_valid) begin
            dec_adaptive <= use_adapt;
            dec_bypass   <= use_adapt && calc_bypass;
            dec_pos      <= use_adapt ? calc_pos : '0;
         end
      end
   end
endmodule

// File: rtl/ris_checker.sv
module ris_checker #(
   parameter int POS_W  = 4,
   parameter int PSEL_W = 10,
   parameter int MARGIN = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_class,
   input logic              dec_valid,
   input logic              dec_bypass,
   input logic [POS_W-1:0]  dec_pos,
   input logic              dec_adaptive,
   input logic [PSEL_W-1:0] psel,
   input logic              reduced
);
   localparam logic [PSEL_W:0] PMAX_X = {1'b0, {PSEL_W{1'b1}}};
   localparam logic [PSEL_W:0] HALF_X = PSEL_W'(1) << (PSEL_W - 1);

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid);
   p_pos_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> ((dec_pos & (dec_pos + POS_W'(1))) == '0));
   p_reuse_mru_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_class == 3'd4) |=> dec_pos == '0);
   p_skip_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_class == 3'd0) |=> (!dec_adaptive || dec_bypass));
   p_lru_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_adaptive) |-> (dec_pos == '0 && !dec_bypass));
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (psel != $past(psel)) |->
         (({1'b0, psel} == {1'b0, $past(psel)} + 1'b1) ||
          ({1'b0, $past(psel)} == {1'b0, psel} + 1'b1)));
   p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reduced) |->
         (({1'b0, $past(psel)} < (PSEL_W + 1)'(MARGIN)) ||
          ({1'b0, $past(psel)} > PMAX_X - (PSEL_W + 1)'(MARGIN))));
   p_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reduced) |->
         (({1'b0, $past(psel)} >= (HALF_X >> 1)) &&
          ({1'b0, $past(psel)} < HALF_X + (HALF_X >> 1))));
endmodule

bind reuse_insert_sel ris_checker #(.POS_W(POS_W), .PSEL_W(PSEL_W), .MARGIN(MARGIN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_class    (req_class),
   .dec_valid    (dec_valid),
   .dec_bypass   (dec_bypass),
   .dec_pos      (dec_pos),
   .dec_adaptive (dec_adaptive),
   .psel         (u_duel.psel_q),
   .reduced      (u_duel.reduced_q)
);

// File: tb/reuse_insert_sel_bench.sv
`timescale 1ns/1ps
module reuse_insert_sel_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [9:0] req_set = '0;
   logic       req_map_reuse = 1'b0;
   logic [7:0] req_zone_reuse = '0;
   logic [7:0] req_zone_access = '0;
   logic [2:0] req_class = 3'd2;
   logic       miss_valid = 1'b0;
   logic [9:0] miss_set = '0;
   logic       dec_valid;
   logic       dec_bypass;
   logic [3:0] dec_pos;
   logic       dec_adaptive;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   reuse_insert_sel u_reuse_insert_sel (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_set (req_set),
      .req_map_reuse (req_map_reuse), .req_zone_reuse (req_zone_reuse),
      .req_zone_access (req_zone_access), .req_class (req_class),
      .miss_valid (miss_valid), .miss_set (miss_set), .dec_valid (dec_valid),
      .dec_bypass (dec_bypass), .dec_pos (dec_pos), .dec_adaptive (dec_adaptive)
   );

   typedef struct packed {
      logic       mr;
      logic [7:0] reuse;
      logic [7:0] access;
      logic [2:0] cls;
      logic [3:0] pos;
      logic       byp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'd10,  8'd20,  3'd2, 4'd15, 1'b0},
      '{1'b1, 8'd10,  8'd20,  3'd2, 4'd7,  1'b0},
      '{1'b1, 8'd30,  8'd20,  3'd2, 4'd3,  1'b0},
      '{1'b0, 8'd30,  8'd20,  3'd2, 4'd7,  1'b0},
      '{1'b1, 8'd30,  8'd20,  3'd3, 4'd1,  1'b0},
      '{1'b0, 8'd5,   8'd5,   3'd3, 4'd7,  1'b0},
      '{1'b1, 8'd30,  8'd20,  3'd1, 4'd15, 1'b0},
      '{1'b0, 8'd0,   8'd0,   3'd4, 4'd0,  1'b0},
      '{1'b0, 8'd1,   8'd16,  3'd2, 4'd15, 1'b0},
      '{1'b0, 8'd1,   8'd17,  3'd2, 4'd15, 1'b1},
      '{1'b0, 8'd0,   8'd1,   3'd4, 4'd0,  1'b1},
      '{1'b1, 8'd200, 8'd255, 3'd0, 4'd7,  1'b1},
      '{1'b1, 8'd9,   8'd3,   3'd7, 4'd3,  1'b0},
      '{1'b0, 8'd15,  8'd255, 3'd3, 4'd7,  1'b1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input logic [9:0] s, input logic mr, input logic [7:0] r,
                       input logic [7:0] a, input logic [2:0] c);
      @(negedge clk);
      req_valid = 1'b1; req_set = s; req_map_reuse = mr;
      req_zone_reuse = r; req_zone_access = a; req_class = c;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic misses(input logic [9:0] s, input int n);
      @(negedge clk);
      miss_valid = 1'b1; miss_set = s;
      repeat (n) @(negedge clk);
      miss_valid = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic policy_of(input logic [9:0] s, input bit exp, input string req);
      send(s, 1'b0, 8'd1, 8'd1, 3'd2);
      check(dec_valid && dec_adaptive == exp, req, int'(dec_adaptive), int'(exp));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(dec_valid == 1'b0, "R9 reset valid", int'(dec_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(dec_valid == 1'b0, "R9 idle after reset", int'(dec_valid), 0);

      // R7: follower is adaptive after reset (counter 512)
      policy_of(10'd5, 1'b1, "R7 reset follower");

      // R2 R3 R4: table on follower set 5
      for (int i = 0; i < NV; i++) begin
         send(10'd5, VEC[i].mr, VEC[i].reuse, VEC[i].access, VEC[i].cls);
         check(dec_pos == VEC[i].pos, "R2/R3 pos", int'(dec_pos), int'(VEC[i].pos));
         check(dec_bypass == VEC[i].byp, "R4 bypass", int'(dec_bypass), int'(VEC[i].byp));
      end

      // R5 R6: same skip inputs on dedicated sets
      send(10'h000, 1'b1, 8'd200, 8'd255, 3'd0);
      check(!dec_adaptive && dec_pos == 0 && !dec_bypass, "R5 LRU set",
            int'({dec_adaptive, dec_bypass, dec_pos}), 0);
      send(10'h01F, 1'b1, 8'd200, 8'd255, 3'd0);
      check(dec_adaptive && dec_pos == 7 && dec_bypass, "R6 adaptive set",
            int'({dec_adaptive, dec_bypass, dec_pos}), 'h37);
      policy_of(10'h3FF, 1'b0, "R6 unkept LRU set full mode");

      // R1: latency
      @(negedge clk);
      req_valid = 1'b1; req_set = 10'd5;
      #1 check(dec_valid == 1'b0, "R1 before edge", int'(dec_valid), 0);
      @(negedge clk);
      req_valid = 1'b0;
      check(dec_valid == 1'b1, "R1 one cycle", int'(dec_valid), 1);
      @(negedge clk);
      check(dec_valid == 1'b0, "R1 drop", int'(dec_valid), 0);

      // R7 R8: drive counter to upper limit
      misses(10'h000, 600);
      policy_of(10'h3FF, 1'b1, "R8 reduced high unkept LRU is follower");
      misses(10'h3E0, 100);               // ignored while reduced (R8)
      misses(10'h01F, 511);               // 1023 -> 512
      policy_of(10'd5, 1'b1, "R7 upper saturation");
      policy_of(10'h3FF, 1'b0, "R8 restored");
      misses(10'h01F, 1);                 // 511
      policy_of(10'd5, 1'b0, "R7 MSB zero");
      misses(10'h01F, 516);               // saturates at 0
      policy_of(10'h3E0, 1'b0, "R8 reduced low unkept adaptive is follower");
      misses(10'h000, 255);               // 255: still reduced
      policy_of(10'd5, 1'b0, "R7 lower saturation");
      policy_of(10'h3E0, 1'b0, "R8 hysteresis");
      misses(10'h000, 1);                 // 256: middle half
      policy_of(10'h3E0, 1'b1, "R8 restore at 256");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule